// File: doc/BRIEF.md
# Zone write-permission filter

This block decides, for a single byte of a write aimed at a user memory zone, whether that byte may be written. It also works out the value that should actually land in storage and how many bytes of the request may go ahead. Each zone carries a two-bit access mode. The mode can be unrestricted, page-locked, clear-only or read-only. The zone that applies is taken from the target address.

In page-locked mode the first byte of every 8-byte page acts as a mask for that page. The byte is fetched from memory by the surrounding logic and presented on `lock_i`. Each mask bit guards one offset of the page, and bit 0 guards the mask byte itself. A page-locked request is cut down to one byte, and the mask byte can only have bits cleared.

The filter evaluates a request in the cycle `req_i` is high and presents a registered result one cycle later, marked by `done_o`. A refused write hands back the old byte, grants zero length and raises `err_o` for that one result cycle. The memory array and the decision about who holds access rights sit outside this block.

Top module: `zone_write_filter`

## Requirements
- R1: The zone of a request is `addr_i[ADDR_W-1:5]` (32-byte zones). Zone z takes its mode from `zone_mode_i[2z+1:2z]`, coded 0 = unrestricted, 1 = page-locked, 2 = clear-only, 3 = read-only.
- R2: After reset `done_o`, `err_o`, `permit_o`, `store_o` and `len_o` are all 0. The result of a request sampled on a clock edge appears on the outputs after that edge, with `done_o` high for exactly that cycle.
- R3: Unrestricted mode always permits, stores `wdata_i` unchanged and passes `len_i` through as `len_o`.
- R4: Page-locked mode, page offset k = `addr_i[2:0]` with k from 1 to 7: the write is permitted only when `lock_i[k]` is 1, and the stored value is `wdata_i`.
- R5: Page-locked mode, offset 0 (the mask byte): the write is permitted only when `lock_i[0]` is 1, and the stored value is `old_i & wdata_i`, so mask bits can never return to 1.
- R6: A permitted page-locked write gets `len_o` = 1, or 0 when `len_i` is 0.
- R7: Clear-only mode permits, stores `old_i & wdata_i` and passes `len_i` through.
- R8: Read-only mode refuses every write.
- R9: A refused write gives `permit_o` = 0, `store_o` = `old_i`, `len_o` = 0 and `err_o` = 1, for the single result cycle only.
- R10: In a cycle after one without `req_i`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; evaluate this cycle |
| addr_i | input | ADDR_W (7) | Target byte address |
| wdata_i | input | 8 | New data byte |
| old_i | input | 8 | Byte currently stored at the target |
| lock_i | input | 8 | Mask byte at offset 0 of the target page |
| len_i | input | LEN_W (5) | Requested write length in bytes |
| zone_mode_i | input | 2*NUM_ZONES (8) | Per-zone access modes |
| done_o | output | 1 | Result valid pulse |
| permit_o | output | 1 | Write of this byte allowed |
| store_o | output | 8 | Value to store |
| len_o | output | LEN_W (5) | Granted write length |
| err_o | output | 1 | Refused-write pulse |

## Verification
The bench builds the filter with its defaults: four 32-byte zones, 8-byte pages and a 5-bit length. With these values one mode word can give each zone a different mode, so a single table covers every mode, every page offset, the self-locked mask byte, zero-length and 16-byte requests. A directed test rewrites the mode word and retargets a zone, which confirms that the mode follows the zone field of the address and is not fixed to an address range.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_WLOCK  = 2'd1,
    MODE_PROG   = 2'd2,
    MODE_FORBID = 2'd3
  } zone_mode_e;
endpackage

// File: rtl/wpf_zone_sel.sv
module wpf_zone_sel
  import wpf_pkg::*;
#(
  parameter int NUM_ZONES  = 4,
  parameter int ZONE_BYTES = 32,
  localparam int ZOFF_W = $clog2(ZONE_BYTES),
  localparam int ZSEL_W = $clog2(NUM_ZONES),
  localparam int ADDR_W = ZOFF_W + ZSEL_W
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [2*NUM_ZONES-1:0] modes_i,
  output zone_mode_e             mode_o
);
  zone_mode_e zone_modes [NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_unpack
    assign zone_modes[z] = zone_mode_e'(modes_i[2*z +: 2]);
  end

  logic [ZSEL_W-1:0] zone_idx;
  assign zone_idx = addr_i[ZOFF_W +: ZSEL_W];
  assign mode_o   = zone_modes[zone_idx];
endmodule

// File: rtl/wpf_lock_eval.sv
module wpf_lock_eval #(
  parameter int PAGE_BYTES = 8,
  localparam int PO_W = $clog2(PAGE_BYTES)
) (
  input  logic [PO_W-1:0]       offset_i,
  input  logic [PAGE_BYTES-1:0] lock_i,
  output logic                  unlocked_o,
  output logic                  is_lock_byte_o
);
  // bit k guards page offset k; bit 0 guards the mask byte itself
  assign unlocked_o     = lock_i[offset_i];
  assign is_lock_byte_o = (offset_i == '0);
endmodule

// File: rtl/zone_write_filter.sv
module zone_write_filter
  import wpf_pkg::*;
#(
  parameter int NUM_ZONES  = 4,
  parameter int ZONE_BYTES = 32,
  parameter int PAGE_BYTES = 8,
  parameter int LEN_W      = 5,
  localparam int ADDR_W = $clog2(ZONE_BYTES) + $clog2(NUM_ZONES),
  localparam int PO_W   = $clog2(PAGE_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  input  logic [7:0]             old_i,
  input  logic [7:0]             lock_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [2*NUM_ZONES-1:0] zone_mode_i,
  output logic                   done_o,
  output logic                   permit_o,
  output logic [7:0]             store_o,
  output logic [LEN_W-1:0]       len_o,
  output logic                   err_o
);
  zone_mode_e mode_d, mode_q;
  logic       unlocked, is_lock_byte;

  wpf_zone_sel #(.NUM_ZONES(NUM_ZONES), .ZONE_BYTES(ZONE_BYTES)) u_zone_sel (
    .addr_i (addr_i),
    .modes_i(zone_mode_i),
    .mode_o (mode_d)
  );

  wpf_lock_eval #(.PAGE_BYTES(PAGE_BYTES)) u_lock_eval (
    .offset_i      (addr_i[PO_W-1:0]),
    .lock_i        (lock_i[PAGE_BYTES-1:0]),
    .unlocked_o    (unlocked),
    .is_lock_byte_o(is_lock_byte)
  );

  logic             permit_d;
  logic [7:0]       store_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    permit_d = 1'b1;
    store_d  = wdata_i;
    len_d    = len_i;
    unique case (mode_d)
      MODE_NORMAL: ;
      MODE_WLOCK: begin
        permit_d = unlocked;
        store_d  = is_lock_byte ? (old_i & wdata_i) : wdata_i;
        len_d    = (len_i != '0) ? LEN_W'(1) : '0;
      end
      MODE_PROG:   store_d  = old_i & wdata_i;
      MODE_FORBID: permit_d = 1'b0;
      default:     permit_d = 1'b0;
    endcase
    if (!permit_d) begin
      store_d = old_i;
      len_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      permit_o <= 1'b0;
      store_o  <= '0;
      len_o    <= '0;
      err_o    <= 1'b0;
      mode_q   <= MODE_NORMAL;
    end else begin
      done_o <= req_i;
      err_o  <= req_i & ~permit_d;
      if (req_i) begin
        permit_o <= permit_d;
        store_o  <= store_d;
        len_o    <= len_d;
        mode_q   <= mode_d;
      end else begin
        permit_o <= 1'b0;
      end
    end
  end

  AST_ERR_IS_REFUSAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !permit_o && len_o == '0)) else $error("err without refusal"); // R9
  AST_REFUSE_KEEPS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !permit_o) |-> (store_o == $past(old_i))) else $error("refusal altered data"); // R9
  AST_PROG_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_PROG) |-> ((store_o & ~$past(old_i)) == 8'h00)) else $error("bit set"); // R7
  AST_WLOCK_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_WLOCK) |-> (len_o <= LEN_W'(1))) else $error("wlock len"); // R6
  AST_FORBID_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_FORBID) |-> (!permit_o && err_o)) else $error("forbid permitted"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (!done_o && !err_o)) else $error("spurious result"); // R10
endmodule

// File: tb/tb_zone_write_filter.sv
`timescale 1ns/1ps
module tb_zone_write_filter;
  localparam int ADDR_W = 7;
  localparam int LEN_W  = 5;
  localparam int NVEC   = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]       wdata_i = '0, old_i = '0, lock_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0]       zone_mode_i = 8'hE4; // z0 normal, z1 wlock, z2 prog, z3 forbid
  logic             done_o, permit_o, err_o;
  logic [7:0]       store_o;
  logic [LEN_W-1:0] len_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  zone_write_filter dut (
    .clk_i, .rst_ni, .req_i, .addr_i, .wdata_i, .old_i, .lock_i, .len_i,
    .zone_mode_i, .done_o, .permit_o, .store_o, .len_o, .err_o
  );

  // addr, wdata, old, lock, len | exp permit, exp store, exp len
  localparam logic [49:0] VECS [NVEC] = '{
    {7'h05, 8'hA5, 8'h3C, 8'h00, 5'd4,  1'b1, 8'hA5, 5'd4},
    {7'h10, 8'h00, 8'hFF, 8'h00, 5'd16, 1'b1, 8'h00, 5'd16},
    {7'h23, 8'h77, 8'h11, 8'h08, 5'd5,  1'b1, 8'h77, 5'd1},
    {7'h2B, 8'h77, 8'h11, 8'hF7, 5'd1,  1'b0, 8'h11, 5'd0},
    {7'h3F, 8'hC3, 8'h00, 8'h80, 5'd1,  1'b1, 8'hC3, 5'd1},
    {7'h28, 8'h0F, 8'hD9, 8'hD9, 5'd3,  1'b1, 8'h09, 5'd1},
    {7'h30, 8'h00, 8'hD8, 8'hD8, 5'd1,  1'b0, 8'hD8, 5'd0},
    {7'h21, 8'h12, 8'h00, 8'hFF, 5'd0,  1'b1, 8'h12, 5'd0},
    {7'h44, 8'hF0, 8'h3C, 8'h00, 5'd2,  1'b1, 8'h30, 5'd2},
    {7'h5F, 8'hFF, 8'h00, 8'h00, 5'd1,  1'b1, 8'h00, 5'd1},
    {7'h60, 8'h55, 8'hAA, 8'h00, 5'd1,  1'b0, 8'hAA, 5'd0},
    {7'h7F, 8'h00, 8'h01, 8'hFF, 5'd8,  1'b0, 8'h01, 5'd0}
  };
  localparam string TAGS [NVEC] = '{
    "R3", "R3", "R4/R6", "R4/R9", "R4", "R5", "R5/R9", "R6",
    "R7", "R7", "R8/R9", "R8/R9"
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input logic [7:0] wd, input logic [7:0] od,
                       input logic [7:0] lk, input logic [LEN_W-1:0] ln);
    @(negedge clk_i);
    addr_i = a; wdata_i = wd; old_i = od; lock_i = lk; len_i = ln; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R2 reset state
    check("R2 done", int'(done_o), 0);
    check("R2 err", int'(err_o), 0);
    check("R2 permit", int'(permit_o), 0);
    check("R2 store", int'(store_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10 idle done", int'(done_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [49:0] v;
      v = VECS[i];
      issue(v[49:43], v[42:35], v[34:27], v[26:19], v[18:14]);
      check({TAGS[i], " R2 done"}, int'(done_o), 1);
      check({TAGS[i], " permit"}, int'(permit_o), int'(v[13]));
      check({TAGS[i], " store"}, int'(store_o), int'(v[12:5]));
      check({TAGS[i], " len"}, int'(len_o), int'(v[4:0]));
      check({TAGS[i], " err"}, int'(err_o), int'(!v[13]));
      @(negedge clk_i);
      check("R9/R10 pulse ends", int'(err_o), 0);
      check("R10 done low", int'(done_o), 0);
    end

    // R1: retarget zone 0 to read-only; zone 1 to unrestricted
    zone_mode_i = 8'hE3;
    issue(7'h05, 8'hA5, 8'h3C, 8'hFF, 5'd4);
    check("R1 zone0 refused", int'(permit_o), 0);
    check("R1 zone0 old kept", int'(store_o), 8'h3C);
    issue(7'h2B, 8'h77, 8'h11, 8'h00, 5'd6);
    check("R1 zone1 unrestricted", int'(permit_o), 1);
    check("R1 zone1 len", int'(len_o), 6);

    // R9 back-to-back refusals keep err high only while results are refusals
    zone_mode_i = 8'hE4;
    @(negedge clk_i);
    addr_i = 7'h61; old_i = 8'h5A; req_i = 1'b1;
    @(negedge clk_i);
    check("R9 first err", int'(err_o), 1);
    addr_i = 7'h02; wdata_i = 8'h99;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R9 err clears on permit", int'(err_o), 0);
    check("R3 store after refusal", int'(store_o), 8'h99);

    // R2 asynchronous reset mid-stream
    issue(7'h60, 8'h00, 8'h00, 8'h00, 5'd1);
    rst_ni = 1'b0;
    #1;
    check("R2 reset clears err", int'(err_o), 0);
    rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule